// File: doc/BRIEF.md
# Twelve-Bit Symbol Error Applicator for a Flash Page Buffer

This block sits after a Reed-Solomon decoder on the read path of a flash controller. The page that was just read is held in an internal byte RAM of 2112 bytes: 2048 data bytes, then 64 spare bytes at addresses 2048 to 2111. The decoder hands over up to four error locations, each a 12-bit symbol index, together with the 12-bit error value for each one. The codeword packs 12-bit symbols back to back across the byte stream, so a symbol correction touches two bytes, and on each byte only the nibble-aligned part of the error value that the symbol occupies.

When `start` is pulsed while the block is idle, the locations and values are captured. All of them are validated before anything is written. If any location is unusable, the page is declared uncorrectable, no byte is written, and `done` pulses with `fail` set. Otherwise each correction is applied in input order as two read-modify-write cycles on the RAM. After that `done` pulses with `fail` clear, and `corr_cnt` holds the number of corrections applied. While the block is idle, a host port loads and reads back the buffer with a one-cycle read latency.

Top module: `rs_err_apply`

## Requirements
- R1: During and right after reset `done`, `fail`, `busy` are 0 and `corr_cnt` is 0.
- R2: For an odd symbol index p, byte floor(3p/2) is XORed with value bits 11:4, and byte floor(3p/2)+1 is XORed with value bits 3:0 placed in bits 7:4.
- R3: For an even symbol index p greater than 0, byte 3p/2-1 is XORed with value bits 11:8 placed in bits 3:0, and byte 3p/2 is XORed with value bits 7:0.
- R4: Index 0 XORs only byte 0, with value bits 7:0. A value above 0xFF at index 0 makes the page uncorrectable.
- R5: Any index above 1374 makes the page uncorrectable.
- R6: On an uncorrectable page no buffer byte changes, `done` pulses with `fail`=1, and `corr_cnt`=0.
- R7: On success `done` is a one-cycle pulse with `fail`=0 and `corr_cnt` equal to `err_num`. With `err_num`=0 the block finishes at once and changes nothing.
- R8: Several corrections that touch the same byte, including a repeated index, all take effect cumulatively.
- R9: An `err_num` above 4 makes the page uncorrectable.
- R10: Index 1365 changes data byte 2047 (value bits 11:4) and spare byte 0 at address 2048 (bits 3:0 in the upper nibble). Index 1374 changes addresses 2060 and 2061.
- R11: Each correction takes exactly two read-modify-write cycles. `done` is high after 4n+1 clock edges counted from the edge that samples `start` for n applied corrections, and after 1 edge for a failed or empty job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a job; sampled only while idle |
| err_num | input | 3 | Number of error entries supplied |
| err_pos | input | 44 | Four 11-bit symbol indices, slot i at bits 11i+10:11i |
| err_val | input | 48 | Four 12-bit error values, slot i at bits 12i+11:12i |
| host_addr | input | 12 | Buffer byte address for host access while idle |
| host_we | input | 1 | Host write strobe, honoured only while idle |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte read at the address of the previous cycle |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle job completion pulse |
| fail | output | 1 | Page uncorrectable; valid with done, held until next start |
| corr_cnt | output | 3 | Corrections applied; valid with done, held until next start |

## Verification
The write-count assertions take for granted that every engine write belongs to the job accepted by the most recent `start` seen while idle. They also assume the host does not expect its writes to land while `busy` is high. The bench raises `start` only after it has observed the previous `done`, and it touches the host port only between jobs. Random jobs draw indices from the valid range and mask the value at index 0 to eight bits. Failure is injected only on purpose through out-of-range indices, oversized index-0 values or an oversized count, so the bench model always knows whether a write may occur.

// File: rtl/rs_apply_pkg.sv
// Shared constants and the controller state type for the symbol error applicator.
// Assumes 12-bit symbols packed back to back over an 8-bit byte stream.
package rs_apply_pkg;
    localparam int SYM_W  = 12;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_RD,
        ST_WR,
        ST_FIN
    } apply_state_t;
endpackage

// File: rtl/rs_sym_map.sv
// Maps one 12-bit symbol index and error value to two byte accesses
// (address and XOR mask each) and flags the index/value as unusable.
// Assumes the buffer is linear: spare bytes directly follow data bytes.
module rs_sym_map
    import rs_apply_pkg::*;
#(
    parameter int PW      = 11,
    parameter int AW      = 12,
    parameter int MAX_POS = 1374
) (
    input  logic [PW-1:0]     pos,
    input  logic [SYM_W-1:0]  val,
    output logic [AW-1:0]     addr_a,
    output logic [BYTE_W-1:0] mask_a,
    output logic [AW-1:0]     addr_b,
    output logic [BYTE_W-1:0] mask_b,
    output logic              bad
);
    logic [PW:0] half;

    // Byte offset of the symbol start: floor(3*pos/2)
    always_comb half = (PW+1)'((3 * 32'(pos)) / 2);

    // Split the value into the two nibble-aligned byte masks
    always_comb begin
        if (pos[0]) begin
            addr_a = AW'(half);
            mask_a = val[11:4];
            addr_b = AW'(half + (PW+1)'(1));
            mask_b = {val[3:0], 4'h0};
        end else if (pos == '0) begin
            addr_a = '0;
            mask_a = '0;
            addr_b = '0;
            mask_b = val[7:0];
        end else begin
            addr_a = AW'(half - (PW+1)'(1));
            mask_a = {4'h0, val[11:8]};
            addr_b = AW'(half);
            mask_b = val[7:0];
        end
    end

    // Unusable: outside the codeword, or index 0 carrying bits above a byte
    always_comb bad = (32'(pos) > MAX_POS) || ((pos == '0) && (val[11:8] != 4'h0));
endmodule

// File: rtl/rs_page_ram.sv
// Single-port page buffer with synchronous read (one-cycle latency).
// Assumes one access per cycle; a write returns the old byte on rdata.
module rs_page_ram
    import rs_apply_pkg::*;
#(
    parameter int DEPTH = 2112,
    parameter int AW    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] mem [DEPTH];

    // Storage write port
    always_ff @(posedge clk) begin
        if (we && (32'(addr) < DEPTH)) mem[addr] <= wdata;
    end

    // Registered read port
    always_ff @(posedge clk) begin
        if (!rst_n)                    rdata <= '0;
        else if (32'(addr) < DEPTH)    rdata <= mem[addr];
        else                           rdata <= '0;
    end
endmodule

// File: rtl/rs_apply_ctrl.sv
// Sequencer: validates all captured entries, then walks them in order,
// issuing a read cycle and a write cycle for each of the two byte accesses.
// Assumes bad_vec reflects the captured entries from the CHECK cycle on.
module rs_apply_ctrl
    import rs_apply_pkg::*;
#(
    parameter int MAX_ERR = 4,
    parameter int CW      = 3,
    parameter int IW      = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CW-1:0]      num_q,
    input  logic [MAX_ERR-1:0] bad_vec,
    output logic               cap_en,
    output logic [IW-1:0]      idx,
    output logic               half,
    output logic               wr_phase,
    output logic               busy,
    output logic               done,
    output logic               fail,
    output logic [CW-1:0]      corr_cnt
);
    apply_state_t state;
    logic any_bad;
    logic last;

    // Validate only the slots that the count enables, plus the count itself
    always_comb begin
        any_bad = (32'(num_q) > MAX_ERR);
        for (int i = 0; i < MAX_ERR; i++) begin
            if (i < 32'(num_q)) any_bad = any_bad | bad_vec[i];
        end
    end

    // Current entry is the last one requested
    always_comb last = ((32'(idx) + 1) == 32'(num_q));

    // Decoded controls
    always_comb begin
        cap_en   = (state == ST_IDLE) && start;
        busy     = (state != ST_IDLE);
        done     = (state == ST_FIN);
        wr_phase = (state == ST_WR);
    end

    // State, entry pointer, access half and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            half     <= 1'b0;
            fail     <= 1'b0;
            corr_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        fail     <= 1'b0;
                        corr_cnt <= '0;
                        state    <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    idx  <= '0;
                    half <= 1'b0;
                    if (any_bad) begin
                        fail  <= 1'b1;
                        state <= ST_FIN;
                    end else if (num_q == '0) begin
                        state <= ST_FIN;
                    end else begin
                        state <= ST_RD;
                    end
                end
                ST_RD: state <= ST_WR;
                ST_WR: begin
                    if (!half) begin
                        half  <= 1'b1;
                        state <= ST_RD;
                    end else begin
                        half <= 1'b0;
                        if (last) begin
                            corr_cnt <= num_q;
                            state    <= ST_FIN;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= ST_RD;
                        end
                    end
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rs_err_apply.sv
// Top: captures up to MAX_ERR symbol corrections, maps each to two byte
// read-modify-writes on the page buffer, and reports count or failure.
// Assumes start is raised only after the previous done when a result matters.
module rs_err_apply
    import rs_apply_pkg::*;
#(
    parameter int DATA_BYTES  = 2048,
    parameter int SPARE_BYTES = 64,
    parameter int MAX_ERR     = 4,
    parameter int MAX_POS     = 1374,
    parameter int POS_W       = 11,
    localparam int PAGE_BYTES = DATA_BYTES + SPARE_BYTES,
    localparam int AW         = $clog2(PAGE_BYTES),
    localparam int CW         = $clog2(MAX_ERR + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [CW-1:0]              err_num,
    input  logic [MAX_ERR*POS_W-1:0]   err_pos,
    input  logic [MAX_ERR*SYM_W-1:0]   err_val,
    input  logic [AW-1:0]              host_addr,
    input  logic                       host_we,
    input  logic [BYTE_W-1:0]          host_wdata,
    output logic [BYTE_W-1:0]          host_rdata,
    output logic                       busy,
    output logic                       done,
    output logic                       fail,
    output logic [CW-1:0]              corr_cnt
);
    localparam int IW = (MAX_ERR > 1) ? $clog2(MAX_ERR) : 1;

    logic                cap_en;
    logic [CW-1:0]       num_q;
    logic [MAX_ERR-1:0]  bad_vec;
    logic [IW-1:0]       idx;
    logic                half;
    logic                wr_phase;
    logic [AW-1:0]       acc_a_addr [MAX_ERR];
    logic [AW-1:0]       acc_b_addr [MAX_ERR];
    logic [BYTE_W-1:0]   acc_a_mask [MAX_ERR];
    logic [BYTE_W-1:0]   acc_b_mask [MAX_ERR];
    logic [AW-1:0]       eng_addr;
    logic [BYTE_W-1:0]   eng_mask;
    logic [AW-1:0]       ram_addr;
    logic                ram_we;
    logic [BYTE_W-1:0]   ram_wdata;
    logic [BYTE_W-1:0]   ram_rdata;

    // Captured entry count
    always_ff @(posedge clk) begin
        if (!rst_n)      num_q <= '0;
        else if (cap_en) num_q <= err_num;
    end

    for (genvar g = 0; g < MAX_ERR; g++) begin : g_slot
        logic [POS_W-1:0] pos_q;
        logic [SYM_W-1:0] val_q;

        // Captured index and value of this slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pos_q <= '0;
                val_q <= '0;
            end else if (cap_en) begin
                pos_q <= err_pos[g*POS_W +: POS_W];
                val_q <= err_val[g*SYM_W +: SYM_W];
            end
        end

        rs_sym_map #(
            .PW      (POS_W),
            .AW      (AW),
            .MAX_POS (MAX_POS)
        ) u_map (
            .pos    (pos_q),
            .val    (val_q),
            .addr_a (acc_a_addr[g]),
            .mask_a (acc_a_mask[g]),
            .addr_b (acc_b_addr[g]),
            .mask_b (acc_b_mask[g]),
            .bad    (bad_vec[g])
        );
    end

    rs_apply_ctrl #(
        .MAX_ERR (MAX_ERR),
        .CW      (CW),
        .IW      (IW)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .num_q    (num_q),
        .bad_vec  (bad_vec),
        .cap_en   (cap_en),
        .idx      (idx),
        .half     (half),
        .wr_phase (wr_phase),
        .busy     (busy),
        .done     (done),
        .fail     (fail),
        .corr_cnt (corr_cnt)
    );

    // Select the access of the current entry
    always_comb begin
        eng_addr = half ? acc_b_addr[idx] : acc_a_addr[idx];
        eng_mask = half ? acc_b_mask[idx] : acc_a_mask[idx];
    end

    // RAM port ownership: engine while busy, host otherwise
    always_comb begin
        ram_addr  = busy ? eng_addr : host_addr;
        ram_we    = busy ? wr_phase : host_we;
        ram_wdata = busy ? (ram_rdata ^ eng_mask) : host_wdata;
    end

    rs_page_ram #(
        .DEPTH (PAGE_BYTES),
        .AW    (AW)
    ) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (ram_addr),
        .we    (ram_we),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    // Host read data
    always_comb host_rdata = ram_rdata;
endmodule

// File: rtl/rs_apply_chk.sv
// Checker for rs_err_apply: counts engine writes per job and relates the
// count to the reported result. Attached by bind below.
module rs_apply_chk #(
    parameter int MAX_ERR = 4,
    parameter int CW      = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          ram_we,
    input logic          done,
    input logic          fail,
    input logic [CW-1:0] corr_cnt
);
    localparam int WCW = $clog2(2 * MAX_ERR + 1) + 1;

    logic [WCW-1:0] wr_cnt;

    // Engine writes since the job was accepted
    always_ff @(posedge clk) begin
        if (!rst_n)                wr_cnt <= '0;
        else if (start && !busy)   wr_cnt <= '0;
        else if (busy && ram_we)   wr_cnt <= wr_cnt + 1'b1;
    end

    // R1: reset clears the result outputs
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!done && !fail && corr_cnt == '0 && !busy));

    // R7: done lasts one cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: failure reports zero corrections
    p_fail_zero_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> (corr_cnt == '0));

    // R6: failure leaves the buffer untouched
    p_fail_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> (wr_cnt == '0));

    // R11: two read-modify-write cycles per applied correction
    p_two_rmw_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail) |-> (32'(wr_cnt) == 2 * 32'(corr_cnt)));

    // R9: a successful job never reports more than the supported count
    p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail) |-> (32'(corr_cnt) <= MAX_ERR));
endmodule

bind rs_err_apply rs_apply_chk #(
    .MAX_ERR (MAX_ERR),
    .CW      (CW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .ram_we   (ram_we),
    .done     (done),
    .fail     (fail),
    .corr_cnt (corr_cnt)
);

// File: tb/tb_rs_err_apply.sv
// Bench: random page contents, directed corner jobs and seeded random jobs,
// checked against a byte-level model of the symbol packing.
module tb_rs_err_apply;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_ERR    = 4;
    localparam int POS_W      = 11;
    localparam int SYM_W      = 12;
    localparam int PAGE       = 2112;
    localparam int AW         = 12;
    localparam int CW         = 3;
    localparam int LAST_POS   = 1374;

    logic                     clk;
    logic                     rst_n;
    logic                     start;
    logic [CW-1:0]            err_num;
    logic [MAX_ERR*POS_W-1:0] err_pos;
    logic [MAX_ERR*SYM_W-1:0] err_val;
    logic [AW-1:0]            host_addr;
    logic                     host_we;
    logic [7:0]               host_wdata;
    logic [7:0]               host_rdata;
    logic                     busy;
    logic                     done;
    logic                     fail;
    logic [CW-1:0]            corr_cnt;

    rs_err_apply dut (
        .clk(clk), .rst_n(rst_n), .start(start), .err_num(err_num),
        .err_pos(err_pos), .err_val(err_val), .host_addr(host_addr),
        .host_we(host_we), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .busy(busy), .done(done), .fail(fail), .corr_cnt(corr_cnt)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] ref_pg [PAGE];
    int job_n;
    int job_pos [MAX_ERR];
    int job_val [MAX_ERR];

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input int a, input int d);
        @(negedge clk);
        host_addr  = AW'(a);
        host_wdata = 8'(d);
        host_we    = 1'b1;
        @(negedge clk);
        host_we    = 1'b0;
    endtask

    task automatic host_rd(input int a, output int d);
        @(negedge clk);
        host_addr = AW'(a);
        host_we   = 1'b0;
        @(posedge clk);
        @(negedge clk);
        d = int'(host_rdata);
    endtask

    // Byte-level model of one correction
    task automatic model_apply(input int p, input int v);
        int c;
        c = (3 * p) / 2;
        if (p == 0) begin
            ref_pg[0] = ref_pg[0] ^ 8'(v);
        end else if (p % 2 == 1) begin
            ref_pg[c]     = ref_pg[c]     ^ 8'(v >> 4);
            ref_pg[c + 1] = ref_pg[c + 1] ^ 8'((v & 15) << 4);
        end else begin
            ref_pg[c - 1] = ref_pg[c - 1] ^ 8'(v >> 8);
            ref_pg[c]     = ref_pg[c]     ^ 8'(v & 255);
        end
    endtask

    task automatic run_job(input string tag);
        bit exp_fail;
        int k;
        int lim;
        int d;
        exp_fail = (job_n > MAX_ERR);
        lim = (job_n < MAX_ERR) ? job_n : MAX_ERR;
        for (int i = 0; i < lim; i++) begin
            if (job_pos[i] > LAST_POS) exp_fail = 1'b1;
            if (job_pos[i] == 0 && job_val[i] > 255) exp_fail = 1'b1;
        end
        @(negedge clk);
        err_num = CW'(job_n);
        for (int i = 0; i < MAX_ERR; i++) begin
            err_pos[i*POS_W +: POS_W] = POS_W'(job_pos[i]);
            err_val[i*SYM_W +: SYM_W] = SYM_W'(job_val[i]);
        end
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        k = 0;
        while (!done && k < 100) begin
            @(posedge clk);
            k++;
            @(negedge clk);
        end
        chk({tag, " R7 done seen"}, int'(done), 1);
        chk({tag, " R6 fail flag"}, int'(fail), int'(exp_fail));
        chk({tag, " R7 corr_cnt"}, int'(corr_cnt), exp_fail ? 0 : job_n);
        chk({tag, " R11 latency"}, k, (exp_fail || job_n == 0) ? 1 : 4 * job_n + 1);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " R7 done pulse width"}, int'(done), 0);
        if (!exp_fail) begin
            for (int i = 0; i < job_n; i++) model_apply(job_pos[i], job_val[i]);
        end
        for (int i = 0; i < lim; i++) begin
            if (job_pos[i] <= LAST_POS) begin
                for (int b = (3 * job_pos[i]) / 2 - 1; b <= (3 * job_pos[i]) / 2 + 1; b++) begin
                    if (b >= 0 && b < PAGE) begin
                        host_rd(b, d);
                        chk($sformatf("%s byte %0d", tag, b), d, int'(ref_pg[b]));
                    end
                end
            end
        end
    endtask

    task automatic set_job(input int n, input int p0, input int v0, input int p1, input int v1,
                           input int p2, input int v2, input int p3, input int v3);
        job_n = n;
        job_pos[0] = p0; job_val[0] = v0;
        job_pos[1] = p1; job_val[1] = v1;
        job_pos[2] = p2; job_val[2] = v2;
        job_pos[3] = p3; job_val[3] = v3;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_bad++;
        $display("FAIL watchdog: actual hung run, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int d;
        void'($urandom(32'd715));
        rst_n = 1'b0; start = 1'b0; err_num = '0; err_pos = '0; err_val = '0;
        host_addr = '0; host_we = 1'b0; host_wdata = '0;
        repeat (3) @(negedge clk);
        chk("R1 done in reset", int'(done), 0);
        chk("R1 fail in reset", int'(fail), 0);
        chk("R1 corr_cnt in reset", int'(corr_cnt), 0);
        chk("R1 busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after reset", int'(done), 0);

        for (int a = 0; a < PAGE; a++) begin
            ref_pg[a] = 8'($urandom);
            host_wr(a, int'(ref_pg[a]));
        end

        set_job(0, 5, 'h123, 0, 0, 0, 0, 0, 0);             run_job("R7 empty");
        set_job(1, 7, 'hABC, 0, 0, 0, 0, 0, 0);             run_job("R2 odd");
        set_job(1, 8, 'h5A3, 0, 0, 0, 0, 0, 0);             run_job("R3 even");
        set_job(2, 21, 'hF0F, 22, 'h3C5, 0, 0, 0, 0);       run_job("R8 shared byte");
        set_job(2, 100, 'h777, 100, 'h777, 0, 0, 0, 0);     run_job("R8 repeated index");
        set_job(4, 1, 'h111, 2, 'h222, 3, 'h333, 4, 'h444); run_job("R8 chain");
        set_job(1, 0, 'h0AB, 0, 0, 0, 0, 0, 0);             run_job("R4 index0 ok");
        set_job(2, 5, 'h9E1, 0, 'h1AB, 0, 0, 0, 0);         run_job("R4 index0 wide");
        set_job(3, 40, 'h456, 1375, 'h001, 41, 'h789, 0, 0); run_job("R5 out of range");
        set_job(2, 2047, 'hFFF, 60, 'h100, 0, 0, 0, 0);     run_job("R5 max index");
        set_job(1, 1365, 'hA5C, 0, 0, 0, 0, 0, 0);          run_job("R10 boundary");
        set_job(2, 1374, 'h3E7, 1366, 'hC18, 0, 0, 0, 0);   run_job("R10 spare");
        set_job(1, 1373, 'h8F1, 0, 0, 0, 0, 0, 0);          run_job("R10 spare odd");
        set_job(5, 10, 'h101, 11, 'h202, 12, 'h303, 13, 'h404); run_job("R9 count five");
        set_job(7, 10, 'h101, 11, 'h202, 12, 'h303, 13, 'h404); run_job("R9 count seven");

        for (int t = 0; t < 40; t++) begin
            int kind;
            job_n = $urandom_range(1, MAX_ERR);
            for (int i = 0; i < MAX_ERR; i++) begin
                job_pos[i] = $urandom_range(0, LAST_POS);
                job_val[i] = $urandom_range(0, 4095);
                if (job_pos[i] == 0) job_val[i] = job_val[i] & 255;
            end
            kind = $urandom_range(0, 7);
            if (kind == 0) job_pos[$urandom_range(0, job_n - 1)] = $urandom_range(LAST_POS + 1, 2047);
            if (kind == 1) begin
                job_pos[job_n - 1] = 0;
                job_val[job_n - 1] = $urandom_range(256, 4095);
            end
            run_job($sformatf("R2 R3 R6 random %0d", t));
        end

        for (int a = 0; a < PAGE; a++) begin
            host_rd(a, d);
            chk($sformatf("R6 R8 full page byte %0d", a), d, int'(ref_pg[a]));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule